// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the effective memory address for a load/store pipeline stage. From a base register value, an index register value, a 2-bit scale code and a signed displacement it builds the address in one clocked step. The address then goes to the memory port together with a request strobe. For an address-only operation it is instead returned as a data result, and no memory access is made.

An update mode serves loops that walk through arrays. It issues the access at base plus displacement and also sends that same sum back to the register file as the new base value. The register file, the memory and the instruction decoder sit outside this block. Inputs are sampled on a rising clock edge when `in_valid` is high. All outputs are registered and appear one cycle later.

Top module: `agu_unit`

## Requirements
- R1: Mode code 0 (base + displacement) gives an address of base plus the displacement sign-extended to 32 bits. Index and scale have no effect in this mode.
- R2: Mode code 1 (base + index) gives base plus index. Scale and displacement have no effect in this mode.
- R3: Mode code 2 (scaled index) gives base plus index shifted left by the scale code. Scale codes 0, 1, 2 and 3 shift by 0, 1, 2 and 3 places, which is a multiplier of 1, 2, 4 or 8.
- R4: Mode code 3 (scaled index + displacement) gives base + (index << scale) + sign-extended displacement in a single operation.
- R5: Mode code 4 (update) issues a memory request at base + sign-extended displacement. In the same cycle it raises `wb_en` for exactly one cycle, with `wb_data` equal to that address.
- R6: Mode code 5 (address only) computes base + (index << scale) + displacement and presents it on `result_data` with `result_valid` high. `mem_req` stays low.
- R7: All address arithmetic wraps modulo 2^32 and raises no error.
- R8: An operation accepted at clock edge N shows its outputs just after edge N, so consecutive operations are handled on consecutive cycles. `mem_req`, `result_valid` and `wb_en` are low in any cycle whose preceding edge had `in_valid` low.
- R9: Mode codes 6 and 7 are reserved. They raise none of `mem_req`, `result_valid` or `wb_en`.
- R10: While `rst_n` is low, every output is zero, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| mode | input | 3 | Addressing mode code (0..5, 6..7 reserved) |
| scale | input | 2 | Index shift amount |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| disp | input | 16 | Signed displacement |
| mem_req | output | 1 | Memory request strobe |
| mem_addr | output | 32 | Effective address to memory |
| result_valid | output | 1 | Address-only result is valid |
| result_data | output | 32 | Address-only result value |
| wb_en | output | 1 | Base register writeback enable |
| wb_data | output | 32 | Updated base value |

## Verification
The bench sends negative displacements, which would come out 65536 too large if they were zero-extended instead of sign-extended. It also sends a nonzero index and scale in the modes that must ignore them, so any leak of those fields into the sum shows up. All four scale codes are driven with the same index, so a swapped or dropped shift amount gives a wrong address. Sums above and below the 32-bit range are included to show the address wraps cleanly.

In update mode the bench checks that the writeback is a single pulse with the right value. For the address-only and reserved codes it confirms that no memory strobe is raised. Back-to-back operations and a reset applied mid-run would expose extra latency or a strobe that stays high.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [2:0] {
      AM_BASE_DISP  = 3'd0,
      AM_BASE_IDX   = 3'd1,
      AM_SCALED     = 3'd2,
      AM_SCALED_DSP = 3'd3,
      AM_UPDATE     = 3'd4,
      AM_ADDR_ONLY  = 3'd5,
      AM_RSVD6      = 3'd6,
      AM_RSVD7      = 3'd7
   } agu_mode_e;

   typedef struct packed {
      logic use_index;
      logic use_disp;
      logic use_scale;
      logic is_mem;
      logic is_addr_only;
      logic is_update;
   } agu_ctl_t;
endpackage

// File: rtl/agu_decode.sv
module agu_decode
   import agu_pkg::*;
(
   input  logic [2:0] mode,
   output agu_ctl_t   ctl
);
   agu_mode_e m;
   assign m = agu_mode_e'(mode);

   always_comb begin
      ctl = '0;
      unique case (m)
         AM_BASE_DISP: begin
            ctl.use_disp = 1'b1;
            ctl.is_mem   = 1'b1;
         end
         AM_BASE_IDX: begin
            ctl.use_index = 1'b1;
            ctl.is_mem    = 1'b1;
         end
         AM_SCALED: begin
            ctl.use_index = 1'b1;
            ctl.use_scale = 1'b1;
            ctl.is_mem    = 1'b1;
         end
         AM_SCALED_DSP: begin
            ctl.use_index = 1'b1;
            ctl.use_scale = 1'b1;
            ctl.use_disp  = 1'b1;
            ctl.is_mem    = 1'b1;
         end
         AM_UPDATE: begin
            ctl.use_disp  = 1'b1;
            ctl.is_mem    = 1'b1;
            ctl.is_update = 1'b1;
         end
         AM_ADDR_ONLY: begin
            ctl.use_index    = 1'b1;
            ctl.use_scale    = 1'b1;
            ctl.use_disp     = 1'b1;
            ctl.is_addr_only = 1'b1;
         end
         default: ctl = '0;
      endcase
   end
endmodule

// File: rtl/agu_scaler.sv
module agu_scaler #(
   parameter int ADDR_W  = 32,
   parameter int SCALE_W = 2
) (
   input  logic [ADDR_W-1:0]  idx_in,
   input  logic [SCALE_W-1:0] shamt,
   input  logic               enable,
   output logic [ADDR_W-1:0]  idx_out
);
   localparam int MAX_SHIFT = (1 << SCALE_W) - 1;

   if (MAX_SHIFT >= ADDR_W) begin : g_bad_scale
      $error("agu_scaler: shift range must stay below ADDR_W");
   end

   logic [ADDR_W-1:0] stage [MAX_SHIFT+1];

   for (genvar s = 0; s <= MAX_SHIFT; s++) begin : g_shift
      assign stage[s] = idx_in << s;
   end

   assign idx_out = enable ? stage[shamt] : idx_in;
endmodule

// File: rtl/agu_adder3.sv
module agu_adder3 #(
   parameter int ADDR_W  = 32,
   parameter bit USE_CSA = 1'b1
) (
   input  logic [ADDR_W-1:0] a,
   input  logic [ADDR_W-1:0] b,
   input  logic [ADDR_W-1:0] c,
   output logic [ADDR_W-1:0] sum
);
   if (USE_CSA) begin : g_csa
      logic [ADDR_W-1:0] psum;
      logic [ADDR_W-1:0] pcar;
      for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
         assign psum[i] = a[i] ^ b[i] ^ c[i];
         assign pcar[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
      end
      assign sum = psum + {pcar[ADDR_W-2:0], 1'b0};
   end else begin : g_direct
      assign sum = a + b + c;
   end
endmodule

// File: rtl/agu_unit.sv
module agu_unit
   import agu_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DISP_W  = 16,
   parameter int SCALE_W = 2,
   parameter bit USE_CSA = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [2:0]         mode,
   input  logic [SCALE_W-1:0] scale,
   input  logic [ADDR_W-1:0]  base,
   input  logic [ADDR_W-1:0]  index,
   input  logic [DISP_W-1:0]  disp,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               result_valid,
   output logic [ADDR_W-1:0]  result_data,
   output logic               wb_en,
   output logic [ADDR_W-1:0]  wb_data
);
   localparam int EXT_W = ADDR_W - DISP_W;

   if (DISP_W < 1 || DISP_W >= ADDR_W) begin : g_bad_disp
      $error("agu_unit: DISP_W must be between 1 and ADDR_W-1");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("agu_unit: ADDR_W too small");
   end

   agu_ctl_t          ctl;
   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] idx_scaled;
   logic [ADDR_W-1:0] idx_term;
   logic [ADDR_W-1:0] disp_term;
   logic [ADDR_W-1:0] eff_addr;

   agu_decode u_dec (
      .mode (mode),
      .ctl  (ctl)
   );

   agu_scaler #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) u_scl (
      .idx_in  (index),
      .shamt   (scale),
      .enable  (ctl.use_scale),
      .idx_out (idx_scaled)
   );

   assign disp_ext  = {{EXT_W{disp[DISP_W-1]}}, disp};
   assign idx_term  = ctl.use_index ? idx_scaled : '0;
   assign disp_term = ctl.use_disp  ? disp_ext   : '0;

   agu_adder3 #(.ADDR_W(ADDR_W), .USE_CSA(USE_CSA)) u_add (
      .a   (base),
      .b   (idx_term),
      .c   (disp_term),
      .sum (eff_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req      <= 1'b0;
         mem_addr     <= '0;
         result_valid <= 1'b0;
         result_data  <= '0;
         wb_en        <= 1'b0;
         wb_data      <= '0;
      end else begin
         mem_req      <= in_valid & ctl.is_mem;
         result_valid <= in_valid & ctl.is_addr_only;
         wb_en        <= in_valid & ctl.is_update;
         if (in_valid & ctl.is_mem)       mem_addr    <= eff_addr;
         if (in_valid & ctl.is_addr_only) result_data <= eff_addr;
         if (in_valid & ctl.is_update)    wb_data     <= eff_addr;
      end
   end
endmodule

// File: rtl/agu_sva.sv
module agu_sva #(
   parameter int ADDR_W  = 32,
   parameter int DISP_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2:0]        mode,
   input logic [ADDR_W-1:0] base,
   input logic [ADDR_W-1:0] index,
   input logic [DISP_W-1:0] disp,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              result_valid,
   input logic              wb_en,
   input logic [ADDR_W-1:0] wb_data
);
   localparam int EXT_W = ADDR_W - DISP_W;

   // R6: an address-only result never comes with a memory request
   p_addr_only_no_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> !mem_req);

   // R5: writeback only accompanies a memory request
   p_wb_with_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> mem_req);

   // R5: writeback value is base plus sign-extended displacement
   p_wb_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> wb_data == $past(base) + {{EXT_W{$past(disp[DISP_W-1])}}, $past(disp)});

   // R8: no strobe without an accepted operation
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!mem_req && !result_valid && !wb_en));

   // R2: two-register sum
   p_base_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 3'd1) |=> (mem_req && mem_addr == $past(base) + $past(index)));

   // R9: reserved codes raise nothing
   p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode[2:1] == 2'b11) |=> (!mem_req && !result_valid && !wb_en));
endmodule

bind agu_unit agu_sva #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .mode         (mode),
   .base         (base),
   .index        (index),
   .disp         (disp),
   .mem_req      (mem_req),
   .mem_addr     (mem_addr),
   .result_valid (result_valid),
   .wb_en        (wb_en),
   .wb_data      (wb_data)
);

// File: tb/agu_unit_test.sv
module agu_unit_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [2:0]  mode;
   logic [1:0]  scale;
   logic [31:0] base;
   logic [31:0] index;
   logic [15:0] disp;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        result_valid;
   logic [31:0] result_data;
   logic        wb_en;
   logic [31:0] wb_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   agu_unit uut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .mode (mode),
      .scale (scale), .base (base), .index (index), .disp (disp),
      .mem_req (mem_req), .mem_addr (mem_addr), .result_valid (result_valid),
      .result_data (result_data), .wb_en (wb_en), .wb_data (wb_data)
   );

   // {mode, scale, base, index, disp, expected address}
   localparam int NV = 15;
   localparam logic [116:0] VEC [NV] = '{
      {3'd0, 2'd3, 32'h1000_0000, 32'hFFFF_FFFF, 16'h0010, 32'h1000_0010}, // R1 index ignored
      {3'd0, 2'd0, 32'h1000_0000, 32'h0000_0000, 16'hFFF0, 32'h0FFF_FFF0}, // R1 negative disp
      {3'd1, 2'd2, 32'h0000_1000, 32'h0000_0234, 16'h7FFF, 32'h0000_1234}, // R2 scale/disp ignored
      {3'd2, 2'd0, 32'h0000_0100, 32'h0000_0005, 16'h0000, 32'h0000_0105}, // R3 x1
      {3'd2, 2'd1, 32'h0000_0100, 32'h0000_0005, 16'h0000, 32'h0000_010A}, // R3 x2
      {3'd2, 2'd2, 32'h0000_0100, 32'h0000_0005, 16'h0000, 32'h0000_0114}, // R3 x4
      {3'd2, 2'd3, 32'h0000_0100, 32'h0000_0005, 16'h0000, 32'h0000_0128}, // R3 x8
      {3'd3, 2'd2, 32'h0000_2000, 32'h0000_0003, 16'h000C, 32'h0000_2018}, // R4
      {3'd3, 2'd3, 32'h0000_2000, 32'h0000_0001, 16'hFFFC, 32'h0000_2004}, // R4 negative disp
      {3'd4, 2'd0, 32'h0000_4000, 32'h0000_0099, 16'h0004, 32'h0000_4004}, // R5
      {3'd5, 2'd2, 32'h0000_0400, 32'h0000_0010, 16'h0008, 32'h0000_0448}, // R6
      {3'd3, 2'd1, 32'hFFFF_FFF0, 32'h0000_0008, 16'h0001, 32'h0000_0001}, // R7 wrap up
      {3'd0, 2'd0, 32'h0000_0004, 32'h0000_0000, 16'hFFF8, 32'hFFFF_FFFC}, // R7 wrap down
      {3'd6, 2'd1, 32'h0000_0010, 32'h0000_0001, 16'h0001, 32'h0000_0000}, // R9
      {3'd7, 2'd1, 32'h0000_0010, 32'h0000_0001, 16'h0001, 32'h0000_0000}  // R9
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] m, input logic [1:0] s, input logic [31:0] b,
                        input logic [31:0] i, input logic [15:0] d);
      in_valid = 1'b1; mode = m; scale = s; base = b; index = i; disp = d;
   endtask

   function automatic string req_of(input logic [2:0] m, input int n);
      if (n >= 11 && n <= 12) return "R7";
      case (m)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return "R6";
         default: return "R9";
      endcase
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      drive(3'd4, 2'd0, 32'h1, 32'h1, 16'h1);
      repeat (3) @(negedge clk);
      // R10: outputs held at zero during reset even with valid input
      check({mem_req, result_valid, wb_en} == 3'b0, "R10", "strobes in reset",
            {29'd0, mem_req, result_valid, wb_en}, 32'd0);
      check(mem_addr == 0 && wb_data == 0 && result_data == 0, "R10", "data in reset",
            mem_addr | wb_data | result_data, 32'd0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      for (int n = 0; n < NV; n++) begin
         logic [116:0] v;
         logic [2:0]   m;
         logic [31:0]  ex;
         string        r;
         v  = VEC[n];
         m  = v[116:114];
         ex = v[31:0];
         r  = req_of(m, n);
         drive(m, v[113:112], v[111:80], v[79:48], v[47:32]);
         @(negedge clk);
         in_valid = 1'b0;
         check(mem_req == (m <= 3'd4), r, "mem_req", {31'd0, mem_req}, {31'd0, m <= 3'd4});
         check(result_valid == (m == 3'd5), r, "result_valid",
               {31'd0, result_valid}, {31'd0, m == 3'd5});
         check(wb_en == (m == 3'd4), r, "wb_en", {31'd0, wb_en}, {31'd0, m == 3'd4});
         if (m <= 3'd4) check(mem_addr == ex, r, "mem_addr", mem_addr, ex);
         if (m == 3'd4) check(wb_data == ex, r, "wb_data", wb_data, ex);
         if (m == 3'd5) check(result_data == ex, r, "result_data", result_data, ex);
         @(negedge clk);
         // R8 / R5: strobes drop after an idle cycle (writeback is a single pulse)
         check({mem_req, result_valid, wb_en} == 3'b0, "R8", "idle strobes",
               {29'd0, mem_req, result_valid, wb_en}, 32'd0);
      end

      // R8: back-to-back operations, one per cycle
      drive(3'd2, 2'd2, 32'h0000_0800, 32'h0000_0002, 16'h0);
      @(negedge clk);
      check(mem_req && mem_addr == 32'h0000_0808, "R8", "first of pair", mem_addr, 32'h0000_0808);
      drive(3'd5, 2'd0, 32'h0000_0900, 32'h0000_0003, 16'hFFFF);
      @(negedge clk);
      in_valid = 1'b0;
      check(!mem_req, "R8", "second of pair mem_req", {31'd0, mem_req}, 32'd0);
      check(result_valid && result_data == 32'h0000_0902, "R8", "second of pair result",
            result_data, 32'h0000_0902);

      // R10: reset mid-run clears a pending update
      drive(3'd4, 2'd0, 32'h0000_0040, 32'h0, 16'h0008);
      @(negedge clk);
      check(wb_en && wb_data == 32'h0000_0048, "R5", "update before reset", wb_data, 32'h48);
      rst_n = 1'b0;
      #1;
      check(!wb_en && !mem_req && wb_data == 0, "R10", "mid-run reset", wb_data, 32'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule